// File: doc/BRIEF.md
# Programmable Down-Counting Timer

A single-channel timer peripheral on a simple single-cycle register bus. A 32-bit counter falls by one on every prescaled clock tick while counting is switched on. The tick rate is the bus clock divided by 1, 16 or 256. The counter can run at its full 32-bit width or in a narrow 16-bit mode. When it passes zero, the counter does one of two things. In periodic mode it reloads from a separate reload register. In free-running mode it wraps to the all-ones value of the selected width.

Each zero crossing sets a sticky event flag. The flag stays set until software writes the clear register. The interrupt line is the flag gated by an interrupt-enable bit. Software can read the live count at any time and can also overwrite it directly. Writing the reload register while counting leaves the current count alone and only affects the next reload.

Top module: `dtimer`

## Requirements
- R1: After reset, every register reads as zero and `irq` is low.
- R2: Byte offsets are 0x00 reload, 0x04 count, 0x08 control and 0x0C flag. Control fields: bit 7 run, bit 6 periodic, bit 5 interrupt enable, bits 3:2 prescale, bit 1 wide. The other control bits read as zero. Offset 0x0C reads the flag in bit 0.
- R3: While run is 0 the count holds, and writing 0 to run stops counting.
- R4: With run set, the count drops by one every N clocks. N is 1 for prescale 00 or 11, 16 for 01 and 256 for 10. The prescale phase restarts when run goes from 0 to 1, so the first decrement lands N clocks after the enabling write.
- R5: With wide clear, the count reads and counts in the low 16 bits only. With wide set, it uses all 32 bits.
- R6: In periodic mode, a tick at zero loads the reload register, masked to the active width.
- R7: In free-running mode, a tick at zero wraps to the all-ones value of the active width.
- R8: Each tick at zero sets the flag. The flag holds until a write to 0x0C. If the set and the clear fall in the same cycle, the set wins.
- R9: `irq` equals the flag ANDed with the interrupt-enable bit.
- R10: A write to the count register presets the count and wins over a tick in the same cycle. A write to the reload register does not change the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | Access is a write |
| busAddr | input | 4 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from `busAddr` |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase shows up as a count read that is one step off, exactly N clocks after the enabling write. The bench therefore reads the count just before and just after that boundary. A bad reload or wrap path shows up as a wrong count on the cycle after the zero tick. A flag that fails to stick, or that drops on a colliding clear, shows up at `irq` and at offset 0x0C within one clock. Randomized runs that pass zero several times in a row show the gap between periodic and free-running behaviour within a few tens of cycles.

// File: rtl/dtimer_pkg.sv
`timescale 1ns/1ps
package dtimer_pkg;
  localparam int unsigned ADDR_W = 4;

  // word index of each register (byte offset >> 2)
  localparam logic [1:0] IDX_RELOAD = 2'd0;
  localparam logic [1:0] IDX_COUNT  = 2'd1;
  localparam logic [1:0] IDX_CTRL   = 2'd2;
  localparam logic [1:0] IDX_FLAG   = 2'd3;

  // control field positions
  localparam int unsigned POS_RUN  = 7;
  localparam int unsigned POS_PER  = 6;
  localparam int unsigned POS_IE   = 5;
  localparam int unsigned POS_PSHI = 3;
  localparam int unsigned POS_PSLO = 2;
  localparam int unsigned POS_WIDE = 1;

  typedef enum logic [1:0] {
    PS_ONE  = 2'b00,
    PS_MID  = 2'b01,
    PS_HIGH = 2'b10,
    PS_RSVD = 2'b11
  } presc_e;

  typedef struct packed {
    logic   run;
    logic   periodic;
    logic   irqEn;
    presc_e presc;
    logic   wide;
  } ctrl_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrReload;
    logic wrCount;
    logic tick;
  } strobe_t;
endpackage

// File: rtl/dtimer_ctrl.sv
`timescale 1ns/1ps
module dtimer_ctrl
  import dtimer_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PRE_MID  = 16,
  parameter int unsigned PRE_HIGH = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  ctrl_t             cfgIn,
  input  logic              zeroNow,
  output ctrl_t             cfg,
  output strobe_t           strobe,
  output logic              flag,
  output logic              clearWr,
  output logic [DATA_W-1:0] ctrlWord
);
  localparam int unsigned PRE_CW = $clog2(PRE_HIGH);

  logic              wrHit;
  logic [1:0]        wrIdx;
  logic [PRE_CW-1:0] preCnt;
  logic [PRE_CW-1:0] preLimit;
  logic              tickNow;
  logic              zeroEvt;

  assign wrHit = busSel && busWrite && (busAddr[1:0] == 2'b00);
  assign wrIdx = busAddr[3:2];

  // control register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (wrHit && wrIdx == IDX_CTRL) begin
      cfg <= cfgIn;
    end
  end

  // prescale terminal count
  always_comb begin
    case (cfg.presc)
      PS_MID:  preLimit = PRE_CW'(PRE_MID - 1);
      PS_HIGH: preLimit = PRE_CW'(PRE_HIGH - 1);
      default: preLimit = '0;
    endcase
  end

  assign tickNow = cfg.run && (preCnt >= preLimit);

  // prescale counter: held at zero while stopped, so a fresh start restarts the phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!cfg.run || tickNow) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign zeroEvt = tickNow && zeroNow;
  assign clearWr = wrHit && wrIdx == IDX_FLAG;

  // sticky event flag, set dominates clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag <= 1'b0;
    end else if (zeroEvt) begin
      flag <= 1'b1;
    end else if (clearWr) begin
      flag <= 1'b0;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.tick     = tickNow;
    strobe.wrCount  = wrHit && wrIdx == IDX_COUNT;
    strobe.wrReload = wrHit && wrIdx == IDX_RELOAD;
  end

  always_comb begin
    ctrlWord           = '0;
    ctrlWord[POS_RUN]  = cfg.run;
    ctrlWord[POS_PER]  = cfg.periodic;
    ctrlWord[POS_IE]   = cfg.irqEn;
    ctrlWord[POS_PSHI] = cfg.presc[1];
    ctrlWord[POS_PSLO] = cfg.presc[0];
    ctrlWord[POS_WIDE] = cfg.wide;
  end
endmodule

// File: rtl/dtimer_dp.sv
`timescale 1ns/1ps
module dtimer_dp
  import dtimer_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wide,
  input  logic              periodic,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] reloadReg,
  output logic [DATA_W-1:0] countVis,
  output logic              zeroNow
);
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] countReg;
  logic [DATA_W-1:0] widthMask;
  logic [DATA_W-1:0] countNext;

  assign widthMask = wide ? {DATA_W{1'b1}} : NARROW_MASK;
  assign countVis  = countReg & widthMask;
  assign zeroNow   = (countVis == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadReg <= '0;
    end else if (strobe.wrReload) begin
      reloadReg <= wdata;
    end
  end

  always_comb begin
    countNext = countReg;
    if (strobe.wrCount) begin
      countNext = wdata;
    end else if (strobe.tick) begin
      if (zeroNow) begin
        countNext = periodic ? (reloadReg & widthMask) : widthMask;
      end else begin
        countNext = (countReg - 1'b1) & widthMask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= '0;
    end else begin
      countReg <= countNext;
    end
  end
endmodule

// File: rtl/dtimer.sv
`timescale 1ns/1ps
module dtimer
  import dtimer_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned PRE_MID  = 16,
  parameter int unsigned PRE_HIGH = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [3:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  ctrl_t             cfgIn;
  ctrl_t             cfg;
  strobe_t           strobe;
  logic              flag;
  logic              clearWr;
  logic              zeroNow;
  logic [DATA_W-1:0] ctrlWord;
  logic [DATA_W-1:0] reloadReg;
  logic [DATA_W-1:0] countVis;

  assign cfgIn.run      = busWdata[POS_RUN];
  assign cfgIn.periodic = busWdata[POS_PER];
  assign cfgIn.irqEn    = busWdata[POS_IE];
  assign cfgIn.presc    = presc_e'(busWdata[POS_PSHI:POS_PSLO]);
  assign cfgIn.wide     = busWdata[POS_WIDE];

  dtimer_ctrl #(
    .DATA_W  (DATA_W),
    .PRE_MID (PRE_MID),
    .PRE_HIGH(PRE_HIGH)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .cfgIn   (cfgIn),
    .zeroNow (zeroNow),
    .cfg     (cfg),
    .strobe  (strobe),
    .flag    (flag),
    .clearWr (clearWr),
    .ctrlWord(ctrlWord)
  );

  dtimer_dp #(
    .DATA_W  (DATA_W),
    .NARROW_W(NARROW_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wide     (cfg.wide),
    .periodic (cfg.periodic),
    .strobe   (strobe),
    .wdata    (busWdata),
    .reloadReg(reloadReg),
    .countVis (countVis),
    .zeroNow  (zeroNow)
  );

  always_comb begin
    busRdata = '0;
    if (busAddr[1:0] == 2'b00) begin
      case (busAddr[3:2])
        IDX_RELOAD: busRdata = reloadReg;
        IDX_COUNT:  busRdata = countVis;
        IDX_CTRL:   busRdata = ctrlWord;
        default:    busRdata = {{(DATA_W-1){1'b0}}, flag};
      endcase
    end
  end

  assign irq = flag && cfg.irqEn;
endmodule

// File: rtl/dtimer_chk.sv
`timescale 1ns/1ps
module dtimer_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic              irq,
  input logic              run,
  input logic              periodic,
  input logic              irqEn,
  input logic              wide,
  input logic              flag,
  input logic              clearWr,
  input logic              tick,
  input logic              zeroNow,
  input logic [DATA_W-1:0] countVis,
  input logic [DATA_W-1:0] reloadReg
);
  logic              anyWr;
  logic [DATA_W-1:0] maskNow;

  assign anyWr   = busSel && busWrite;
  assign maskNow = wide ? {DATA_W{1'b1}} : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN) irq |-> (irqEn && flag)); // R9
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rstN) (!run && !anyWr) |=> $stable(countVis)); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN) (tick && !zeroNow && !anyWr) |=> (countVis == $past(countVis) - 1'b1)); // R4
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rstN) (tick && zeroNow && periodic && !anyWr) |=> (countVis == ($past(reloadReg) & $past(maskNow)))); // R6
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rstN) (tick && zeroNow && !periodic && !anyWr) |=> (countVis == $past(maskNow))); // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN) (tick && zeroNow) |=> flag); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN) (flag && !clearWr) |=> flag); // R8
endmodule

bind dtimer dtimer_chk #(
  .DATA_W  (DATA_W),
  .NARROW_W(NARROW_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .irq      (irq),
  .run      (cfg.run),
  .periodic (cfg.periodic),
  .irqEn    (cfg.irqEn),
  .wide     (cfg.wide),
  .flag     (flag),
  .clearWr  (clearWr),
  .tick     (strobe.tick),
  .zeroNow  (zeroNow),
  .countVis (countVis),
  .reloadReg(reloadReg)
);

// File: tb/dtimer_bench.sv
`timescale 1ns/1ps
module dtimer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = 4'h0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_RELOAD = 4'h0;
  localparam logic [3:0] A_COUNT  = 4'h4;
  localparam logic [3:0] A_CTRL   = 4'h8;
  localparam logic [3:0] A_FLAG   = 4'hC;

  always #5 clk = ~clk;

  dtimer u_dtimer (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .irq     (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one write occupies exactly one rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference: count after n ticks at prescale 1
  function automatic logic [31:0] mdlRun(input logic [31:0] start, input logic [31:0] reload,
                                         input bit wide, input bit per, input int n,
                                         output bit crossed);
    logic [31:0] m;
    logic [31:0] c;
    m = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    c = start & m;
    crossed = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (c == 0) begin
        crossed = 1'b1;
        c = per ? (reload & m) : m;
      end else begin
        c = c - 1;
      end
    end
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_RELOAD, d); check("R1 reload", d, 32'h0);
    rd(A_COUNT, d);  check("R1 count", d, 32'h0);
    rd(A_CTRL, d);   check("R1 ctrl", d, 32'h0);
    rd(A_FLAG, d);   check("R1 flag", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 register map
    wr(A_RELOAD, 32'hA5A5_1234);
    rd(A_RELOAD, d); check("R2 reload readback", d, 32'hA5A5_1234);
    wr(A_CTRL, 32'hFFFF_FF7F);
    rd(A_CTRL, d); check("R2 ctrl fields", d, 32'h0000_006E);
    wr(A_CTRL, 32'h0);

    // R3 hold while stopped
    wr(A_CTRL, 32'h02);
    wr(A_COUNT, 32'h1000);
    step(20);
    rd(A_COUNT, d); check("R3 hold stopped", d, 32'h1000);

    // R4 prescale 1, then stop (R3)
    wr(A_CTRL, 32'h82);
    step(7);
    rd(A_COUNT, d); check("R4 div1", d, 32'h1000 - 7);
    wr(A_CTRL, 32'h02);
    step(5);
    rd(A_COUNT, d); check("R3 stop freezes", d, 32'h1000 - 8);

    // R4 prescale 16
    wr(A_COUNT, 32'h500);
    wr(A_CTRL, 32'h86);
    step(15);
    rd(A_COUNT, d); check("R4 div16 before", d, 32'h500);
    step(1);
    rd(A_COUNT, d); check("R4 div16 first", d, 32'h4FF);
    step(16);
    rd(A_COUNT, d); check("R4 div16 second", d, 32'h4FE);
    wr(A_CTRL, 32'h02);

    // R4 phase restarts on enable
    wr(A_COUNT, 32'h500);
    wr(A_CTRL, 32'h86);
    step(10);
    wr(A_CTRL, 32'h02);
    wr(A_CTRL, 32'h86);
    step(15);
    rd(A_COUNT, d); check("R4 restart no tick", d, 32'h500);
    step(1);
    rd(A_COUNT, d); check("R4 restart tick", d, 32'h4FF);
    wr(A_CTRL, 32'h02);

    // R4 prescale 256
    wr(A_COUNT, 32'h40);
    wr(A_CTRL, 32'h8A);
    step(255);
    rd(A_COUNT, d); check("R4 div256 before", d, 32'h40);
    step(1);
    rd(A_COUNT, d); check("R4 div256 tick", d, 32'h3F);
    wr(A_CTRL, 32'h02);

    // R4 reserved prescale acts as 1
    wr(A_COUNT, 32'h40);
    wr(A_CTRL, 32'h8E);
    step(3);
    rd(A_COUNT, d); check("R4 reserved div1", d, 32'h3D);
    wr(A_CTRL, 32'h02);

    // R5 narrow width, R7 narrow wrap
    wr(A_CTRL, 32'h00);
    wr(A_FLAG, 32'h0);
    wr(A_COUNT, 32'h0001_2345);
    rd(A_COUNT, d); check("R5 narrow read", d, 32'h2345);
    wr(A_COUNT, 32'h0003_0001);
    wr(A_CTRL, 32'h80);
    step(1);
    rd(A_COUNT, d); check("R5 narrow zero", d, 32'h0);
    step(1);
    rd(A_COUNT, d); check("R7 narrow wrap", d, 32'hFFFF);
    rd(A_FLAG, d); check("R8 flag on wrap", d, 32'h1);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h00);

    // R7 wide wrap
    wr(A_FLAG, 32'h0);
    wr(A_CTRL, 32'h02);
    wr(A_COUNT, 32'h1);
    wr(A_CTRL, 32'h82);
    step(2);
    rd(A_COUNT, d); check("R7 wide wrap", d, 32'hFFFF_FFFF);
    step(1);
    rd(A_COUNT, d); check("R7 after wrap", d, 32'hFFFF_FFFE);
    wr(A_CTRL, 32'h02);

    // R6 periodic reload, R9 irq, R10 reload write
    wr(A_FLAG, 32'h0);
    wr(A_RELOAD, 32'h5);
    wr(A_COUNT, 32'h3);
    wr(A_CTRL, 32'hE2);
    step(3);
    rd(A_COUNT, d); check("R6 reaches zero", d, 32'h0);
    check("R9 irq low before", {31'b0, irq}, 32'h0);
    step(1);
    rd(A_COUNT, d); check("R6 reload", d, 32'h5);
    rd(A_FLAG, d); check("R8 flag set", d, 32'h1);
    check("R9 irq high", {31'b0, irq}, 32'h1);
    wr(A_RELOAD, 32'h9);
    rd(A_COUNT, d); check("R10 reload write keeps count", d, 32'h4);
    step(4);
    rd(A_COUNT, d); check("R6 zero again", d, 32'h0);
    step(1);
    rd(A_COUNT, d); check("R6 new reload", d, 32'h9);
    wr(A_CTRL, 32'hC2);
    check("R9 irq off with ie clear", {31'b0, irq}, 32'h0);
    rd(A_FLAG, d); check("R8 flag sticky", d, 32'h1);
    wr(A_CTRL, 32'hE2);
    check("R9 irq back", {31'b0, irq}, 32'h1);
    wr(A_FLAG, 32'h0);
    rd(A_FLAG, d); check("R8 flag cleared", d, 32'h0);
    check("R9 irq cleared", {31'b0, irq}, 32'h0);

    // R10 count write wins over tick; R8 set beats clear
    wr(A_COUNT, 32'h1);
    rd(A_COUNT, d); check("R10 preset wins", d, 32'h1);
    step(1);
    wr(A_FLAG, 32'h0);
    rd(A_FLAG, d); check("R8 set beats clear", d, 32'h1);
    rd(A_COUNT, d); check("R6 reload on collision", d, 32'h9);
    wr(A_CTRL, 32'h02);

    // random runs at prescale 1
    for (int it = 0; it < 24; it++) begin
      bit wideR, perR, ieR, crossed;
      logic [1:0]  psR;
      logic [31:0] startR, reloadR, exp;
      int k;
      wideR   = $urandom % 2;
      perR    = $urandom % 2;
      ieR     = $urandom % 2;
      psR     = ($urandom % 2) ? 2'b11 : 2'b00;
      startR  = ($urandom % 2) ? ($urandom % 40) : ($urandom | 32'h0001_0000) % 32'h0001_0030;
      reloadR = $urandom % 30;
      k       = $urandom % 60;
      wr(A_CTRL, 32'h0);
      wr(A_FLAG, 32'h0);
      wr(A_RELOAD, reloadR);
      wr(A_COUNT, startR);
      wr(A_CTRL, {24'h0, 1'b1, perR, ieR, 1'b0, psR, wideR, 1'b0});
      step(k);
      exp = mdlRun(startR, reloadR, wideR, perR, k, crossed);
      rd(A_COUNT, d);
      check(perR ? "R6 random count" : "R7 random count", d, exp);
      rd(A_FLAG, d); check("R8 random flag", d, {31'b0, crossed});
      check("R9 random irq", {31'b0, irq}, {31'b0, crossed & ieR});
    end
    wr(A_CTRL, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule